// File: doc/BRIEF.md
# Return-Address LIFO with Occupancy Watermark Interrupt

This block is a last-in-first-out store for return addresses. A sequencer pushes the address when it enters a subroutine or an interrupt service routine and pops it on return. The most recent entry is always available on a combinational read port. Storage is 33 entries deep by default. The data width and the depth are parameters, so the same block also serves as an 8-deep or 16-deep stack.

The stack reports its occupancy as a count, together with full and empty indications. Two sticky error flags record a push that was refused because the stack was full and a pop that found nothing. Both flags stay set until reset.

A level interrupt request warns software before the stack runs dry or overflows. It is asserted while fewer than 3 entries are held or while more than 28 are held. Both thresholds are parameters. The request is gated by an enable input that comes from the interrupt controller's stack-interrupt control bit; in the core's interrupt map this request takes priority slot 2, with vector 0x040.

Top module: `lifo_level_stack`

## Requirements
- R1: While reset is asserted and just after it, the stack holds nothing: fill count 0, empty 1, full 0, both error flags 0, and the top-of-stack output reads 0.
- R2: A push alone, when the stack is not full, stores the input word as the new top and raises the fill count by one at the next clock edge.
- R3: A push alone, when the stack holds DEPTH entries, writes nothing and leaves the count and the top unchanged. It sets the overflow flag, which then stays 1 until reset.
- R4: A pop alone, when the stack is not empty, lowers the count by one. The top output then shows the entry that was pushed before the popped one (last in, first out).
- R5: A pop alone on an empty stack sets the underflow flag, which then stays 1 until reset. The count stays 0, and the top output reads 0 whenever the stack is empty.
- R6: A push and a pop in the same cycle on a non-empty stack overwrite the top entry with the input word and leave the count unchanged. This holds when the stack is full as well, and it does not set the overflow flag.
- R7: A push and a pop in the same cycle on an empty stack write nothing. The count stays 0 and the underflow flag is set.
- R8: With the enable input high, the level interrupt output is 1 while the fill count is below LOW_MARK (default 3).
- R9: With the enable input high, the level interrupt output is 1 while the fill count is above HIGH_MARK (default 28).
- R10: The level interrupt output is 0 whenever the enable input is 0, and also whenever the count lies from LOW_MARK to HIGH_MARK inclusive. The request is a level, not a pulse.
- R11: The full output is 1 exactly when the count equals DEPTH, and the empty output is 1 exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | DATA_W | Word to push |
| irq_enable_i | input | 1 | Stack-level interrupt enable from the interrupt controller |
| top_data_o | output | DATA_W | Current top entry, 0 when empty |
| fill_o | output | $clog2(DEPTH+1) | Number of entries held |
| full_o | output | 1 | Count equals DEPTH |
| empty_o | output | 1 | Count is zero |
| overflow_o | output | 1 | Sticky: push refused while full |
| underflow_o | output | 1 | Sticky: pop attempted while empty |
| level_irq_o | output | 1 | Watermark interrupt request (level) |

## Verification
A push, pop or combined request is sampled on a rising edge. The count, the top output, the full and empty indications and the flags all show the result straight after that same edge, one cycle of latency in total. The interrupt request and the top output are decoded combinationally from the registered count. The enable input therefore affects the request within the cycle it changes, with no register in between. The bench applies each request half a period before an edge, steps a queue-based model at that edge, and compares every output at the following falling edge, so each result is read in the cycle it is due.

// File: rtl/stack_pkg.sv
package stack_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2,
      OP_SWAP = 2'd3
   } stack_op_e;

   function automatic stack_op_e decode_op(input logic push, input logic pop);
      unique case ({pop, push})
         2'b01:   return OP_PUSH;
         2'b10:   return OP_POP;
         2'b11:   return OP_SWAP;
         default: return OP_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
   import stack_pkg::*;
#(
   parameter int DEPTH = 33,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stack_op_e        op,
   output logic [CNT_W-1:0] fill,
   output logic             full,
   output logic             empty,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] rd_idx,
   output logic             ovf,
   output logic             unf
);

   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

   assign full   = (fill == FULL_C);
   assign empty  = (fill == '0);
   assign rd_idx = IDX_W'(fill - ONE_C);

   always_comb begin
      wr_en  = 1'b0;
      wr_idx = IDX_W'(fill);
      unique case (op)
         OP_PUSH: wr_en = !full;
         OP_SWAP: begin
            wr_en  = !empty;
            wr_idx = rd_idx;
         end
         default: wr_en = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
         ovf  <= 1'b0;
         unf  <= 1'b0;
      end else begin
         unique case (op)
            OP_PUSH: begin
               if (full) ovf <= 1'b1;
               else      fill <= fill + ONE_C;
            end
            OP_POP: begin
               if (empty) unf <= 1'b1;
               else       fill <= fill - ONE_C;
            end
            OP_SWAP: begin
               if (empty) unf <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   // R2: push into a non-full stack raises the count by one
   a_r2_push_count: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PUSH && !full) |=> (fill == $past(fill) + ONE_C));
   // R3: refused push keeps the stack full and records overflow
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PUSH && full) |=> (ovf && fill == FULL_C));
   // R3: overflow flag is sticky
   a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   // R4: pop from a non-empty stack lowers the count by one
   a_r4_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_POP && !empty) |=> (fill == $past(fill) - ONE_C));
   // R5: underflow flag is sticky
   a_r5_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> unf);
   // R7: combined request on an empty stack leaves it empty
   a_r7_swap_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SWAP && empty) |=> (unf && fill == '0));
   // R11: count never exceeds the depth
   a_r11_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_C);

endmodule

// File: rtl/stack_store.sv
module stack_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 33,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IDX_W'(g)) cells[g] <= wr_data;
      end
   end

   assign rd_data = rd_valid ? cells[rd_idx] : '0;

endmodule

// File: rtl/level_mon.sv
module level_mon #(
   parameter int CNT_W     = 6,
   parameter int LOW_MARK  = 3,
   parameter int HIGH_MARK = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] fill,
   input  logic             enable,
   output logic             irq
);

   localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_MARK);
   localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(HIGH_MARK);

   logic below_low, above_high;

   assign below_low  = (fill < LOW_C);
   assign above_high = (fill > HIGH_C);
   assign irq        = enable & (below_low | above_high);

   // R10: no request while disabled
   a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !irq);
   // R10: no request inside the band
   a_r10_band: assert property (@(posedge clk) disable iff (!rst_n)
      (fill >= LOW_C && fill <= HIGH_C) |-> !irq);

endmodule

// File: rtl/lifo_level_stack.sv
module lifo_level_stack
   import stack_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 33,
   parameter int LOW_MARK  = 3,
   parameter int HIGH_MARK = 28,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              irq_enable_i,
   output logic [DATA_W-1:0] top_data_o,
   output logic [CNT_W-1:0]  fill_o,
   output logic              full_o,
   output logic              empty_o,
   output logic              overflow_o,
   output logic              underflow_o,
   output logic              level_irq_o
);

   if (DATA_W < 1)               $error("DATA_W must be at least 1");
   if (DEPTH < 2)                $error("DEPTH must be at least 2");
   if (LOW_MARK < 0)             $error("LOW_MARK must not be negative");
   if (HIGH_MARK < LOW_MARK)     $error("HIGH_MARK must not be below LOW_MARK");
   if (HIGH_MARK >= DEPTH)       $error("HIGH_MARK must be below DEPTH");

   stack_op_e        op;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx, rd_idx;

   assign op = decode_op(push_i, pop_i);

   stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .fill   (fill_o),
      .full   (full_o),
      .empty  (empty_o),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .rd_idx (rd_idx),
      .ovf    (overflow_o),
      .unf    (underflow_o)
   );

   stack_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (push_data_i),
      .rd_valid (!empty_o),
      .rd_idx   (rd_idx),
      .rd_data  (top_data_o)
   );

   level_mon #(.CNT_W(CNT_W), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .fill   (fill_o),
      .enable (irq_enable_i),
      .irq    (level_irq_o)
   );

   // R2: pushed word becomes the visible top
   a_r2_push_top: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !full_o) |=> (top_data_o == $past(push_data_i)));
   // R6: combined request replaces the top and keeps the count
   a_r6_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !empty_o) |=> ($stable(fill_o) && top_data_o == $past(push_data_i)));
   // R5: empty stack reads as zero
   a_r5_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |-> (top_data_o == '0));
   // R8: enabled request below the low mark
   a_r8_low: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_enable_i && fill_o < CNT_W'(LOW_MARK)) |-> level_irq_o);
   // R9: enabled request above the high mark
   a_r9_high: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_enable_i && fill_o > CNT_W'(HIGH_MARK)) |-> level_irq_o);
   // R11: full and empty never together
   a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_o && empty_o));

endmodule

// File: tb/tb_lifo_level_stack.sv
`timescale 1ns/1ps
module tb_lifo_level_stack;

   localparam int DW    = 16;
   localparam int DEPTH = 33;
   localparam int LOW   = 3;
   localparam int HIGH  = 28;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_i = 1'b0, pop_i = 1'b0, irq_enable_i = 1'b0;
   logic [DW-1:0] push_data_i = '0;
   logic [DW-1:0] top_data_o;
   logic [CW-1:0] fill_o;
   logic          full_o, empty_o, overflow_o, underflow_o, level_irq_o;

   always #4 clk = ~clk;

   lifo_level_stack #(.DATA_W(DW), .DEPTH(DEPTH), .LOW_MARK(LOW), .HIGH_MARK(HIGH)) dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .push_data_i(push_data_i), .irq_enable_i(irq_enable_i),
      .top_data_o(top_data_o), .fill_o(fill_o), .full_o(full_o), .empty_o(empty_o),
      .overflow_o(overflow_o), .underflow_o(underflow_o), .level_irq_o(level_irq_o));

   int checks = 0, fails = 0;
   bit done = 0;
   int model_q[$];
   bit m_ovf = 0, m_unf = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string op_tag);
      int n = model_q.size();
      int exp_top = (n == 0) ? 0 : model_q[n-1];
      string irq_tag = !irq_enable_i ? "R10" : (n < LOW) ? "R8" : (n > HIGH) ? "R9" : "R10";
      chk(op_tag, "fill", int'(fill_o), n);
      chk(op_tag, "top", int'(top_data_o), exp_top);
      chk("R11", "full", int'(full_o), int'(n == DEPTH));
      chk("R11", "empty", int'(empty_o), int'(n == 0));
      chk("R3", "overflow", int'(overflow_o), int'(m_ovf));
      chk("R5", "underflow", int'(underflow_o), int'(m_unf));
      chk(irq_tag, "irq", int'(level_irq_o),
          int'(irq_enable_i && (n < LOW || n > HIGH)));
   endtask

   task automatic step(input bit pu, input bit po, input logic [DW-1:0] d);
      string tag;
      int n;
      push_i = pu; pop_i = po; push_data_i = d;
      @(posedge clk);
      n = model_q.size();
      if (pu && po) begin
         if (n == 0) begin m_unf = 1; tag = "R7"; end
         else begin model_q[n-1] = int'(d); tag = "R6"; end
      end else if (pu) begin
         if (n == DEPTH) begin m_ovf = 1; tag = "R3"; end
         else begin model_q.push_back(int'(d)); tag = "R2"; end
      end else if (po) begin
         if (n == 0) begin m_unf = 1; tag = "R5"; end
         else begin void'(model_q.pop_back()); tag = "R4"; end
      end else tag = "R10";
      @(negedge clk);
      push_i = 0; pop_i = 0;
      compare_all(tag);
   endtask

   task automatic do_reset();
      push_i = 0; pop_i = 0;
      rst_n = 0;
      @(posedge clk);
      @(negedge clk);
      model_q.delete(); m_ovf = 0; m_unf = 0;
      compare_all("R1");
      rst_n = 1;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      finish_up();
   end

   initial begin
      @(negedge clk);
      do_reset();
      irq_enable_i = 1;
      // R2/R4 basic order, R8 request at low occupancy
      for (int i = 0; i < 5; i++) step(1, 0, DW'(16'h1000 + i));
      for (int i = 0; i < 5; i++) step(0, 1, '0);
      // R5 pop on empty, R7 combined on empty
      step(0, 1, '0);
      step(1, 1, 16'hBEEF);
      do_reset();
      irq_enable_i = 1;
      // R9 fill to full, R3 overflow
      for (int i = 0; i < DEPTH; i++) step(1, 0, DW'(16'hA000 + 3 * i));
      step(1, 0, 16'h5555);
      step(1, 0, 16'h6666);
      // R6 at full, no overflow change
      step(1, 1, 16'h7777);
      // R10 disable while full
      irq_enable_i = 0;
      @(negedge clk);
      compare_all("R10");
      irq_enable_i = 1;
      for (int i = 0; i < DEPTH; i++) begin
         step(0, 1, '0);
         if (i == 10) irq_enable_i = 0;
         if (i == 20) irq_enable_i = 1;
      end
      do_reset();
      irq_enable_i = 1;
      // mixed traffic
      for (int i = 0; i < 3000; i++) begin
         int r = int'($urandom % 10);
         if (r == 9) irq_enable_i = ~irq_enable_i;
         if (r < 4)       step(1, 0, DW'($urandom));
         else if (r < 7)  step(0, 1, '0);
         else if (r == 7) step(1, 1, DW'($urandom));
         else             step(0, 0, '0);
         if (i == 1500) do_reset();
      end
      finish_up();
   end

endmodule